// File: doc/BRIEF.md
# Strap-Loaded Hub Configuration Register

This block holds one 8-bit configuration byte for a USB hub controller and turns its bits into the hub's control outputs. On the first clock edge after the power-on reset is released, the byte takes five of its bits from strap pins. The two string-enable bits start at zero. After that, a new byte can come from only one source, chosen by an interface-mode input. In I2C mode the source is an EEPROM loader strobe. In SMBus mode the source is a host write strobe. The strobe from the other source is ignored. The lowest bit is reserved: it is never stored and always reads as zero.

The outputs are decoded from the byte:
- String and serial-number enables.
- Port-indicator and ganged flags.
- A link power-management gate that blocks U1/U2 when the disable bit is set. A sticky force-accept flag re-opens the gate until reset or an upstream disconnect.
- A per-downstream-port U1/U2 timeout override. When the override is on, any nonzero programmed timeout becomes all ones and zero stays zero.
- Power-switching and over-current-detection enables. These follow the power-management bit and whether the hub is self-powered.

Top module: `hubcfg_reg`

## Requirements
- R1: While `rstN` is low, `rdData` is 0 and the stored byte is 0. At the first rising edge with `rstN` high, stored bits 5..1 take `strapIn[4:0]` (bit n+1 takes `strapIn[n]`) and bits 7 and 6 become 0. Load and write strobes in that cycle are not applied.
- R2: Bit 0 of the byte is reserved. It always reads as 0, whatever value is loaded or written.
- R3: With `busMode`=0 (I2C), a cycle with `eeLoad`=1 replaces bits 7..1 with `eeData[7:1]` at the next edge. `smbWr` has no effect.
- R4: With `busMode`=1 (SMBus), a cycle with `smbWr`=1 replaces bits 7..1 with `smbData[7:1]` at the next edge. `eeLoad` has no effect.
- R5: A cycle with `rdStb`=1 puts the byte as stored before that edge onto `rdData` at the edge. `rdData` holds its value otherwise.
- R6: `customStrEn`, `customSerEn`, `portIndOut` and `gangedOut` show bits 7, 6, 4 and 3.
- R7: `lpmEnable` is 0 only while bit 5 is 1 and the force-accept flag is clear.
- R8: A `forceAcceptEv` pulse sets the force-accept flag. Only reset or an `upDisconnect` pulse clears it, and the disconnect wins if both occur in one cycle. Loads and writes of the byte leave the flag unchanged.
- R9: With bit 1 at 1, each port's `effTimeout` is all ones when its `swTimeout` is nonzero and 0 when it is zero. With bit 1 at 0, `effTimeout` equals `swTimeout`.
- R10: With bit 2 at 0, `pwrSwitchEn` and `ovrCurEn` are both 1. With bit 2 at 1, `pwrSwitchEn` = not `selfPowered` and `ovrCurEn` = `selfPowered`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, asynchronous, active low |
| strapIn | input | 5 | Strap pin levels for bits 5..1 |
| busMode | input | 1 | 0 = I2C (EEPROM source), 1 = SMBus (host source) |
| eeLoad | input | 1 | EEPROM loader strobe |
| eeData | input | 8 | EEPROM loader byte |
| smbWr | input | 1 | SMBus host write strobe |
| smbData | input | 8 | SMBus host byte |
| rdStb | input | 1 | Read strobe |
| rdData | output | 8 | Read data, one cycle after the strobe |
| forceAcceptEv | input | 1 | Force-accept message pulse (sent or received) |
| upDisconnect | input | 1 | Upstream disconnect pulse |
| selfPowered | input | 1 | 1 = hub is self-powered |
| swTimeout | input | NUM_PORTS*TMO_W | Software U1/U2 timeouts, port 0 in the low bits |
| effTimeout | output | NUM_PORTS*TMO_W | Effective U1/U2 timeouts |
| lpmEnable | output | 1 | U1/U2 may be initiated or accepted |
| pwrSwitchEn | output | 1 | Port power switching enabled |
| ovrCurEn | output | 1 | Over-current detection enabled |
| customStrEn | output | 1 | Custom strings enable |
| customSerEn | output | 1 | Custom serial number enable |
| portIndOut | output | 1 | Port indicator flag |
| gangedOut | output | 1 | Ganged power flag |

## Verification
The bench builds the block with NUM_PORTS=3 and TMO_W=8. Three ports show that the timeout clamp is applied to each lane on its own. Port 0 gets zero, port 1 gets a small nonzero value and port 2 gets a mid-range value. With this mix, both outcomes of the clamp and the pass-through case are visible in a single cycle. The 8-bit width means the clamped value is 0xFF.

// File: rtl/hubcfg_pkg.sv
package hubcfg_pkg;
  localparam int CFG_W  = 8;
  localparam int B_STR  = 7;
  localparam int B_SER  = 6;
  localparam int B_LPMO = 5;
  localparam int B_IND  = 4;
  localparam int B_GANG = 3;
  localparam int B_PWR  = 2;
  localparam int B_TMO  = 1;
  localparam int STRAP_W = B_LPMO - B_TMO + 1;

  typedef struct packed {
    logic capStrap;
    logic loadEe;
    logic loadSmb;
    logic rdLatch;
    logic setForce;
    logic clrForce;
  } cfgStrobes_t;
endpackage

// File: rtl/hubcfg_ctrl.sv
module hubcfg_ctrl
  import hubcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busMode,
  input  logic        eeLoad,
  input  logic        smbWr,
  input  logic        rdStb,
  input  logic        forceAcceptEv,
  input  logic        upDisconnect,
  output cfgStrobes_t stb
);
  logic strapped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strapped <= 1'b0;
    else       strapped <= 1'b1;
  end

  always_comb begin
    stb          = '0;
    stb.capStrap = !strapped;
    stb.loadEe   = strapped && !busMode && eeLoad;
    stb.loadSmb  = strapped && busMode && smbWr;
    stb.rdLatch  = rdStb;
    stb.setForce = forceAcceptEv;
    stb.clrForce = upDisconnect;
  end
endmodule

// File: rtl/hubcfg_dp.sv
module hubcfg_dp
  import hubcfg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int TMO_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cfgStrobes_t                stb,
  input  logic [STRAP_W-1:0]         strapIn,
  input  logic [CFG_W-1:0]           eeData,
  input  logic [CFG_W-1:0]           smbData,
  input  logic                       selfPowered,
  input  logic [NUM_PORTS*TMO_W-1:0] swTimeout,
  output logic [NUM_PORTS*TMO_W-1:0] effTimeout,
  output logic [CFG_W-1:0]           rdData,
  output logic                       lpmEnable,
  output logic                       pwrSwitchEn,
  output logic                       ovrCurEn,
  output logic                       customStrEn,
  output logic                       customSerEn,
  output logic                       portIndOut,
  output logic                       gangedOut
);
  localparam logic [CFG_W-1:0] WR_MASK = {{(CFG_W-1){1'b1}}, 1'b0};

  logic [CFG_W-1:0] cfgQ;
  logic [CFG_W-1:0] cfgNext;
  logic             forceSeen;

  always_comb begin
    cfgNext = cfgQ;
    if (stb.capStrap) begin
      cfgNext = '0;
      cfgNext[B_LPMO:B_TMO] = strapIn;
    end else if (stb.loadEe) begin
      cfgNext = eeData & WR_MASK;
    end else if (stb.loadSmb) begin
      cfgNext = smbData & WR_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= '0;
      rdData <= '0;
    end else begin
      cfgQ <= cfgNext;
      if (stb.rdLatch) rdData <= cfgQ & WR_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             forceSeen <= 1'b0;
    else if (stb.clrForce) forceSeen <= 1'b0;
    else if (stb.setForce) forceSeen <= 1'b1;
  end

  assign lpmEnable   = !cfgQ[B_LPMO] || forceSeen;
  assign pwrSwitchEn = !cfgQ[B_PWR] || !selfPowered;
  assign ovrCurEn    = !cfgQ[B_PWR] || selfPowered;
  assign customStrEn = cfgQ[B_STR];
  assign customSerEn = cfgQ[B_SER];
  assign portIndOut  = cfgQ[B_IND];
  assign gangedOut   = cfgQ[B_GANG];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tmo
    logic [TMO_W-1:0] swVal;
    assign swVal = swTimeout[p*TMO_W +: TMO_W];
    always_comb begin
      if (cfgQ[B_TMO]) effTimeout[p*TMO_W +: TMO_W] = (swVal != '0) ? '1 : '0;
      else             effTimeout[p*TMO_W +: TMO_W] = swVal;
    end
  end
endmodule

// File: rtl/hubcfg_reg.sv
module hubcfg_reg
  import hubcfg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int TMO_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [4:0]                 strapIn,
  input  logic                       busMode,
  input  logic                       eeLoad,
  input  logic [7:0]                 eeData,
  input  logic                       smbWr,
  input  logic [7:0]                 smbData,
  input  logic                       rdStb,
  output logic [7:0]                 rdData,
  input  logic                       forceAcceptEv,
  input  logic                       upDisconnect,
  input  logic                       selfPowered,
  input  logic [NUM_PORTS*TMO_W-1:0] swTimeout,
  output logic [NUM_PORTS*TMO_W-1:0] effTimeout,
  output logic                       lpmEnable,
  output logic                       pwrSwitchEn,
  output logic                       ovrCurEn,
  output logic                       customStrEn,
  output logic                       customSerEn,
  output logic                       portIndOut,
  output logic                       gangedOut
);
  cfgStrobes_t stb;

  hubcfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busMode(busMode), .eeLoad(eeLoad),
    .smbWr(smbWr), .rdStb(rdStb), .forceAcceptEv(forceAcceptEv),
    .upDisconnect(upDisconnect), .stb(stb)
  );

  hubcfg_dp #(.NUM_PORTS(NUM_PORTS), .TMO_W(TMO_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .strapIn(strapIn),
    .eeData(eeData), .smbData(smbData), .selfPowered(selfPowered),
    .swTimeout(swTimeout), .effTimeout(effTimeout), .rdData(rdData),
    .lpmEnable(lpmEnable), .pwrSwitchEn(pwrSwitchEn), .ovrCurEn(ovrCurEn),
    .customStrEn(customStrEn), .customSerEn(customSerEn),
    .portIndOut(portIndOut), .gangedOut(gangedOut)
  );
endmodule

// File: rtl/hubcfg_chk.sv
module hubcfg_chk #(
  parameter int NUM_PORTS = 4,
  parameter int TMO_W     = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busMode,
  input logic                       eeLoad,
  input logic                       smbWr,
  input logic                       rdStb,
  input logic [7:0]                 rdData,
  input logic                       forceAcceptEv,
  input logic                       upDisconnect,
  input logic [NUM_PORTS*TMO_W-1:0] swTimeout,
  input logic [NUM_PORTS*TMO_W-1:0] effTimeout,
  input logic                       lpmEnable,
  input logic                       pwrSwitchEn,
  input logic                       ovrCurEn,
  input logic                       customStrEn,
  input logic                       customSerEn
);
  logic started;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN) rdData[0] == 1'b0);

  // R8
  force_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forceAcceptEv && !upDisconnect) |=> lpmEnable);

  // R10
  pwr_cover_chk: assert property (@(posedge clk) disable iff (!rstN) pwrSwitchEn || ovrCurEn);

  // R4
  ee_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && busMode && eeLoad && !smbWr) |=> ($stable(customStrEn) && $stable(customSerEn)));

  // R3
  smb_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (started && !busMode && smbWr && !eeLoad) |=> ($stable(customStrEn) && $stable(customSerEn)));

  // R5
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |=> (rdData[7:6] == {$past(customStrEn), $past(customSerEn)}));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tmo_chk
    // R9
    tmo_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((effTimeout[p*TMO_W +: TMO_W] == '0) == (swTimeout[p*TMO_W +: TMO_W] == '0)));
  end
endmodule

bind hubcfg_reg hubcfg_chk #(.NUM_PORTS(NUM_PORTS), .TMO_W(TMO_W)) u_chk (
  .clk(clk), .rstN(rstN), .busMode(busMode), .eeLoad(eeLoad), .smbWr(smbWr),
  .rdStb(rdStb), .rdData(rdData), .forceAcceptEv(forceAcceptEv),
  .upDisconnect(upDisconnect), .swTimeout(swTimeout), .effTimeout(effTimeout),
  .lpmEnable(lpmEnable), .pwrSwitchEn(pwrSwitchEn), .ovrCurEn(ovrCurEn),
  .customStrEn(customStrEn), .customSerEn(customSerEn)
);

// File: tb/hubcfg_reg_bench.sv
`timescale 1ns/1ps
module hubcfg_reg_bench;
  localparam int NP = 3;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] strapIn = '0;
  logic busMode = 1'b0, eeLoad = 1'b0, smbWr = 1'b0, rdStb = 1'b0;
  logic [7:0] eeData = '0, smbData = '0;
  logic [7:0] rdData;
  logic forceAcceptEv = 1'b0, upDisconnect = 1'b0, selfPowered = 1'b0;
  logic [NP*TW-1:0] swTimeout = '0;
  logic [NP*TW-1:0] effTimeout;
  logic lpmEnable, pwrSwitchEn, ovrCurEn, customStrEn, customSerEn, portIndOut, gangedOut;

  int nChecks = 0;
  int nFails  = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  hubcfg_reg #(.NUM_PORTS(NP), .TMO_W(TW)) u_hubcfg_reg (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .busMode(busMode),
    .eeLoad(eeLoad), .eeData(eeData), .smbWr(smbWr), .smbData(smbData),
    .rdStb(rdStb), .rdData(rdData), .forceAcceptEv(forceAcceptEv),
    .upDisconnect(upDisconnect), .selfPowered(selfPowered),
    .swTimeout(swTimeout), .effTimeout(effTimeout), .lpmEnable(lpmEnable),
    .pwrSwitchEn(pwrSwitchEn), .ovrCurEn(ovrCurEn), .customStrEn(customStrEn),
    .customSerEn(customSerEn), .portIndOut(portIndOut), .gangedOut(gangedOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic readCfg(output logic [7:0] v);
    rdStb = 1'b1; tick(); rdStb = 1'b0; v = rdData;
  endtask

  task automatic doReset(input logic [4:0] s);
    rstN = 1'b0; strapIn = s; eeLoad = 1'b1; eeData = 8'hFF;
    tick(); tick();
    chk("R1 rdData in reset", rdData, 8'h00);
    chk("R1 strEn in reset", customStrEn, 1'b0);
    rstN = 1'b1; tick(); eeLoad = 1'b0;
  endtask

  task automatic tStrap();
    logic [7:0] v;
    doReset(5'b10110);
    readCfg(v);
    chk("R1 strap capture", v, 8'b0010_1100);
    chk("R6 portInd", portIndOut, 1'b0);
    chk("R6 ganged", gangedOut, 1'b1);
    doReset(5'b01001);
    readCfg(v);
    chk("R1 strap capture 2", v, 8'b0001_0010);
    chk("R6 portInd 2", portIndOut, 1'b1);
  endtask

  task automatic tI2c();
    logic [7:0] v;
    busMode = 1'b0;
    eeData = 8'hC3; eeLoad = 1'b1; tick(); eeLoad = 1'b0;
    readCfg(v);
    chk("R3 ee load", v, 8'hC2);
    chk("R2 bit0 zero", v[0], 1'b0);
    chk("R6 strEn", customStrEn, 1'b1);
    chk("R6 serEn", customSerEn, 1'b1);
    smbData = 8'h00; smbWr = 1'b1; tick(); smbWr = 1'b0;
    readCfg(v);
    chk("R3 smb ignored", v, 8'hC2);
  endtask

  task automatic tSmb();
    logic [7:0] v;
    busMode = 1'b1;
    smbData = 8'h59; smbWr = 1'b1; tick(); smbWr = 1'b0;
    readCfg(v);
    chk("R4 smb write", v, 8'h58);
    eeData = 8'hFF; eeLoad = 1'b1; tick(); eeLoad = 1'b0;
    readCfg(v);
    chk("R4 ee ignored", v, 8'h58);
    chk("R6 ganged", gangedOut, 1'b1);
  endtask

  task automatic tRead();
    logic [7:0] v;
    busMode = 1'b1;
    smbData = 8'h80; smbWr = 1'b1; tick();
    smbData = 8'h40; rdStb = 1'b1; tick(); smbWr = 1'b0; rdStb = 1'b0;
    chk("R5 old value on read", rdData, 8'h80);
    tick();
    chk("R5 hold", rdData, 8'h80);
    readCfg(v);
    chk("R5 new value", v, 8'h40);
  endtask

  task automatic tLpm();
    busMode = 1'b1;
    smbData = 8'h20; smbWr = 1'b1; tick(); smbWr = 1'b0;
    chk("R7 gated", lpmEnable, 1'b0);
    forceAcceptEv = 1'b1; tick(); forceAcceptEv = 1'b0;
    chk("R8 force set", lpmEnable, 1'b1);
    smbData = 8'h20; smbWr = 1'b1; tick(); smbWr = 1'b0;
    chk("R8 write keeps flag", lpmEnable, 1'b1);
    forceAcceptEv = 1'b1; upDisconnect = 1'b1; tick();
    forceAcceptEv = 1'b0; upDisconnect = 1'b0;
    chk("R8 disconnect wins", lpmEnable, 1'b0);
    smbData = 8'h00; smbWr = 1'b1; tick(); smbWr = 1'b0;
    chk("R7 bit clear enables", lpmEnable, 1'b1);
  endtask

  task automatic tTimeout();
    busMode = 1'b1;
    swTimeout = {8'h7E, 8'h01, 8'h00};
    smbData = 8'h02; smbWr = 1'b1; tick(); smbWr = 1'b0;
    chk("R9 clamp", effTimeout, {8'hFF, 8'hFF, 8'h00});
    smbData = 8'h00; smbWr = 1'b1; tick(); smbWr = 1'b0;
    chk("R9 pass", effTimeout, {8'h7E, 8'h01, 8'h00});
  endtask

  task automatic tPower();
    busMode = 1'b1;
    smbData = 8'h00; smbWr = 1'b1; tick(); smbWr = 1'b0;
    selfPowered = 1'b1; #1;
    chk("R10 full mgmt", {pwrSwitchEn, ovrCurEn}, 2'b11);
    smbData = 8'h04; smbWr = 1'b1; tick(); smbWr = 1'b0;
    chk("R10 self", {pwrSwitchEn, ovrCurEn}, 2'b01);
    selfPowered = 1'b0; #1;
    chk("R10 bus", {pwrSwitchEn, ovrCurEn}, 2'b10);
  endtask

  initial begin
    tStrap();
    tI2c();
    tSmb();
    tRead();
    tLpm();
    tTimeout();
    tPower();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule